// File: doc/BRIEF.md
# Initialization Block Fetcher

This block loads the start-up configuration of a network controller from system memory. A one-cycle INIT command starts a sequence that reads twelve consecutive 16-bit words from a word-aligned base address. It issues one read at a time over a request/grant interface and waits for each returned word before it moves to the next address.

As the words arrive, the block unpacks them into a set of configuration fields: a 16-bit mode word, a 48-bit station address, a 64-bit multicast filter mask, and the receive and transmit descriptor ring pointers. Each ring pointer carries an 8-byte-aligned ring address and a 3-bit size code, which the block expands into an entry count. When the last word has been taken, the block pulses a completion flag. At the same moment it raises the transmitter-on and receiver-on flags, unless the mode word disables them. It also reports whether the mode word selects normal operation, external loopback or internal loopback.

Top module: `init_block_fetch`

## Requirements
- R1: After reset, `busy`, `init_done`, `mem_req`, `tx_on` and `rx_on` are 0. A reset during a fetch abandons it and returns the block to idle.
- R2: An `init_cmd` seen while idle starts a fetch. From the next cycle `busy` is 1 and `mem_req` is 1, with `mem_addr` equal to `base_addr` with bit 0 forced to 0.
- R3: Each request holds `mem_req` and `mem_addr` steady until `mem_gnt`. The block then waits for `mem_rvalid` and the word on `mem_rdata`. The next request is at the previous address plus 2. Exactly 12 words are read, at base+0 through base+22.
- R4: `station_addr` is built from the words at base+2 (bits 15:0), base+4 (bits 31:16) and base+6 (bits 47:32).
- R5: `mcast_mask` is built from the words at base+8 through base+14, with base+8 as bits 15:0 and each following word 16 bits higher.
- R6: The receive ring pointer is the 32-bit value {word at base+18, word at base+16}, and the transmit ring pointer is {base+22, base+20}. The ring address output is bits 23:0 of the pointer with bits 2:0 reported as 0. Pointer bits 28:24 have no effect on any output.
- R7: Pointer bits 31:29 are a size code n. The entries output equals 2^n (8 bits wide, so 1 to 128).
- R8: `init_done` is 1 for exactly one cycle: the cycle after the one in which the twelfth word is returned. `busy` is 0 in that same cycle.
- R9: At completion, `tx_on` becomes the inverse of mode bit 1 and `rx_on` becomes the inverse of mode bit 0. Both flags clear when a fetch starts.
- R10: `op_mode` is 0 (normal) when mode bit 2 is 0, 1 (external loopback) when bit 2 is 1 and bit 6 is 0, and 2 (internal loopback) when bits 2 and 6 are both 1.
- R11: An `init_cmd` seen while busy has no effect. The running fetch continues at its original addresses and still reads 12 words.
- R12: `mode_word` is the full 16-bit word read at base+0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_cmd | input | 1 | Start a fetch |
| base_addr | input | 24 | Byte address of the block (bit 0 ignored) |
| mem_req | output | 1 | Read request |
| mem_addr | output | 24 | Read byte address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Fetch in progress |
| init_done | output | 1 | One-cycle completion pulse |
| mode_word | output | 16 | Mode word |
| station_addr | output | 48 | Station address |
| mcast_mask | output | 64 | Multicast filter mask |
| rx_ring_addr | output | 24 | Receive ring address |
| rx_ring_entries | output | 8 | Receive ring entry count |
| tx_ring_addr | output | 24 | Transmit ring address |
| tx_ring_entries | output | 8 | Transmit ring entry count |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| op_mode | output | 2 | 0 normal, 1 external loopback, 2 internal loopback |

## Verification
The memory model varies grant and data latency from zero to several cycles. A sequencer that advanced on the grant rather than on returned data would then read the wrong address or the wrong word. Each request address is compared with base plus twice the word count. This catches an odd base leaking through, a skipped word, or a restart caused by a second INIT during a fetch.

The ring words carry all-ones reserved bits and size codes 0 and 7, so that an off-by-one field slice or a leaking reserved bit shows up in the outputs. Mode words that disable one or both directions, and that select each loopback kind, expose a swapped or ungated on-flag. The completion pulse is checked in the exact cycle after the last data beat and must fall one cycle later. A reset in the middle of a fetch must leave the block idle.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
    localparam int WORD_W      = 16;
    localparam int BLOCK_WORDS = 12;
    localparam int LEN_W       = 3;
    localparam int ENT_W       = 1 << LEN_W;
    localparam int RING_AW     = 24;
    localparam int RING_ALIGN  = 3;
    localparam int NUM_RINGS   = 2;

    // word slots inside the block
    localparam int W_MODE  = 0;
    localparam int W_STA0  = 1;
    localparam int N_STA   = 3;
    localparam int W_MASK0 = 4;
    localparam int N_MASK  = 4;
    localparam int W_RING0 = 8;   // ring r uses slots W_RING0+2r (low) and +1 (high)

    // mode word bit positions
    localparam int MB_NO_RX = 0;
    localparam int MB_NO_TX = 1;
    localparam int MB_LOOP  = 2;
    localparam int MB_INNER = 6;

    typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_REQ = 2'd1, FS_WAIT = 2'd2} fetch_state_e;
    typedef enum logic [1:0] {OPM_NORMAL = 2'd0, OPM_EXT_LOOP = 2'd1, OPM_INT_LOOP = 2'd2} op_mode_e;
endpackage

// File: rtl/ifetch_seq.sv
module ifetch_seq
    import ifetch_pkg::*;
#(
    parameter int AW     = 24,
    parameter int NWORDS = BLOCK_WORDS,
    localparam int IW    = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_cmd,
    input  logic [AW-1:0] base_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    output logic          busy,
    output logic          start,
    output logic          finish,
    output logic          word_we,
    output logic [IW-1:0] word_idx,
    output logic          init_done
);
    typedef struct packed {
        fetch_state_e  st;
        logic [AW-1:0] addr;
        logic [IW-1:0] idx;
        logic          done;
    } seq_s;

    seq_s seq_d, seq_q;
    logic last_word;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        start      = 1'b0;
        finish     = 1'b0;
        word_we    = 1'b0;
        last_word  = (seq_q.idx == IW'(NWORDS - 1));
        case (seq_q.st)
            FS_IDLE: begin
                if (init_cmd) begin
                    start      = 1'b1;
                    seq_d.st   = FS_REQ;
                    seq_d.addr = base_addr & ~AW'(1);
                    seq_d.idx  = '0;
                end
            end
            FS_REQ: begin
                if (mem_gnt) seq_d.st = FS_WAIT;
            end
            FS_WAIT: begin
                if (mem_rvalid) begin
                    word_we = 1'b1;
                    if (last_word) begin
                        finish     = 1'b1;
                        seq_d.st   = FS_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.idx  = seq_q.idx + 1'b1;
                        seq_d.addr = seq_q.addr + AW'(2);
                        seq_d.st   = FS_REQ;
                    end
                end
            end
            default: seq_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: FS_IDLE, addr: '0, idx: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_req   = (seq_q.st == FS_REQ);
    assign mem_addr  = seq_q.addr;
    assign busy      = (seq_q.st != FS_IDLE);
    assign word_idx  = seq_q.idx;
    assign init_done = seq_q.done;

    // R3: an ungranted request keeps its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R3: the next word is two bytes further on
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && !finish) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(2)));

    // R2: a start from idle requests the even base
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && init_cmd) |=> (mem_req && mem_addr == ($past(base_addr) & ~AW'(1))));

    // R2: requests are always word aligned
    p_addr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);
endmodule

// File: rtl/ifetch_ringlen.sv
module ifetch_ringlen
    import ifetch_pkg::*;
#(
    parameter int CW = LEN_W,
    localparam int EW = 1 << CW
) (
    input  logic [CW-1:0] code,
    output logic [EW-1:0] entries
);
    always_comb begin
        entries = EW'(1) << code;
    end
endmodule

// File: rtl/ifetch_unpack.sv
module ifetch_unpack
    import ifetch_pkg::*;
#(
    localparam int IW = $clog2(BLOCK_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_we,
    input  logic [IW-1:0]       word_idx,
    input  logic [WORD_W-1:0]   word_data,
    output logic [WORD_W-1:0]   mode_word,
    output logic [47:0]         station_addr,
    output logic [63:0]         mcast_mask,
    output logic [RING_AW-1:0]  rx_ring_addr,
    output logic [ENT_W-1:0]    rx_ring_entries,
    output logic [RING_AW-1:0]  tx_ring_addr,
    output logic [ENT_W-1:0]    tx_ring_entries
);
    typedef struct packed {
        logic [WORD_W-1:0]                               mode;
        logic [N_STA*WORD_W-1:0]                         sta;
        logic [N_MASK*WORD_W-1:0]                        mask;
        logic [NUM_RINGS-1:0][RING_AW-1:RING_ALIGN]      raddr;
        logic [NUM_RINGS-1:0][LEN_W-1:0]                 rcode;
    } fields_s;

    fields_s fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (word_we) begin
            if (word_idx == IW'(W_MODE)) fld_d.mode = word_data;
            for (int i = 0; i < N_STA; i++) begin
                if (word_idx == IW'(W_STA0 + i)) fld_d.sta[i*WORD_W +: WORD_W] = word_data;
            end
            for (int i = 0; i < N_MASK; i++) begin
                if (word_idx == IW'(W_MASK0 + i)) fld_d.mask[i*WORD_W +: WORD_W] = word_data;
            end
            for (int r = 0; r < NUM_RINGS; r++) begin
                if (word_idx == IW'(W_RING0 + 2*r)) begin
                    fld_d.raddr[r][WORD_W-1:RING_ALIGN] = word_data[WORD_W-1:RING_ALIGN];
                end
                if (word_idx == IW'(W_RING0 + 2*r + 1)) begin
                    // high word: size code on top, reserved middle dropped, address byte below
                    fld_d.raddr[r][RING_AW-1:WORD_W] = word_data[RING_AW-WORD_W-1:0];
                    fld_d.rcode[r] = word_data[WORD_W-1 -: LEN_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end

    logic [NUM_RINGS-1:0][RING_AW-1:0] ring_addr;
    logic [NUM_RINGS-1:0][ENT_W-1:0]   ring_ent;

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        assign ring_addr[r] = {fld_q.raddr[r], {RING_ALIGN{1'b0}}};
        ifetch_ringlen #(.CW(LEN_W)) u_len (
            .code    (fld_q.rcode[r]),
            .entries (ring_ent[r])
        );
    end

    assign mode_word       = fld_q.mode;
    assign station_addr    = fld_q.sta;
    assign mcast_mask      = fld_q.mask;
    assign rx_ring_addr    = ring_addr[0];
    assign rx_ring_entries = ring_ent[0];
    assign tx_ring_addr    = ring_addr[1];
    assign tx_ring_entries = ring_ent[1];
endmodule

// File: rtl/init_block_fetch.sv
module init_block_fetch
    import ifetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_cmd,
    input  logic [23:0] base_addr,
    output logic        mem_req,
    output logic [23:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        init_done,
    output logic [15:0] mode_word,
    output logic [47:0] station_addr,
    output logic [63:0] mcast_mask,
    output logic [23:0] rx_ring_addr,
    output logic [7:0]  rx_ring_entries,
    output logic [23:0] tx_ring_addr,
    output logic [7:0]  tx_ring_entries,
    output logic        tx_on,
    output logic        rx_on,
    output logic [1:0]  op_mode
);
    localparam int IW = $clog2(BLOCK_WORDS);

    logic          start, finish, word_we;
    logic [IW-1:0] word_idx;

    ifetch_seq #(.AW(24), .NWORDS(BLOCK_WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_cmd   (init_cmd),
        .base_addr  (base_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .busy       (busy),
        .start      (start),
        .finish     (finish),
        .word_we    (word_we),
        .word_idx   (word_idx),
        .init_done  (init_done)
    );

    ifetch_unpack u_unpack (
        .clk             (clk),
        .rst_n           (rst_n),
        .word_we         (word_we),
        .word_idx        (word_idx),
        .word_data       (mem_rdata),
        .mode_word       (mode_word),
        .station_addr    (station_addr),
        .mcast_mask      (mcast_mask),
        .rx_ring_addr    (rx_ring_addr),
        .rx_ring_entries (rx_ring_entries),
        .tx_ring_addr    (tx_ring_addr),
        .tx_ring_entries (tx_ring_entries)
    );

    typedef struct packed {
        logic tx;
        logic rx;
    } onflags_s;

    onflags_s on_d, on_q;

    always_comb begin
        on_d = on_q;
        if (start) begin
            on_d = '0;
        end else if (finish) begin
            on_d.tx = !mode_word[MB_NO_TX];
            on_d.rx = !mode_word[MB_NO_RX];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= '0;
        else        on_q <= on_d;
    end

    assign tx_on = on_q.tx;
    assign rx_on = on_q.rx;

    always_comb begin
        if (!mode_word[MB_LOOP])      op_mode = OPM_NORMAL;
        else if (mode_word[MB_INNER]) op_mode = OPM_INT_LOOP;
        else                          op_mode = OPM_EXT_LOOP;
    end

    // R9: the on flags only rise together with the completion pulse
    p_tx_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |-> init_done);
    p_rx_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_on) |-> init_done);
    // R9: a running fetch never shows an enabled direction
    p_off_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!tx_on && !rx_on));
endmodule

// File: tb/sim_init_block_fetch.sv
module sim_init_block_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    localparam int NW = 12;

    localparam logic [23:0] V_BASE [NV] = '{24'h001000, 24'h00ABC1, 24'hFFFFE8, 24'h000002, 24'h7F0000};
    localparam int          V_GL   [NV] = '{0, 2, 1, 3, 0};
    localparam int          V_RL   [NV] = '{0, 1, 3, 0, 2};
    localparam logic [15:0] V_MODE [NV] = '{16'h0000, 16'h0003, 16'h0044, 16'h0006, 16'h0039};
    localparam logic [15:0] V_SEED [NV] = '{16'hA5C3, 16'h1234, 16'h0F0F, 16'hFFFF, 16'h8000};
    localparam logic [2:0]  V_RXC  [NV] = '{3'd0, 3'd7, 3'd3, 3'd5, 3'd1};
    localparam logic [2:0]  V_TXC  [NV] = '{3'd7, 3'd0, 3'd6, 3'd2, 3'd4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_cmd = 1'b0;
    logic [23:0] base_addr = '0;
    logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic mem_req, busy, init_done, tx_on, rx_on;
    logic [23:0] mem_addr, rx_ring_addr, tx_ring_addr;
    logic [15:0] mode_word;
    logic [47:0] station_addr;
    logic [63:0] mcast_mask;
    logic [7:0]  rx_ring_entries, tx_ring_entries;
    logic [1:0]  op_mode;

    init_block_fetch u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] img(int v, int k);
        logic [15:0] r = V_SEED[v] ^ (16'(k) * 16'h3131);
        case (k)
            0:       return V_MODE[v];
            9:       return {V_RXC[v], 5'h1F, r[7:0]};
            11:      return {V_TXC[v], 5'h1F, r[7:0]};
            default: return r;
        endcase
    endfunction

    // memory model state
    int cur_v = 0, cur_gl = 0, cur_rl = 0, served = 0, mst = 0, gcnt = 0, rcnt = 0;
    logic [23:0] exp_base = '0;
    bit pend_done = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (pend_done) begin
                chk(init_done == 1'b1, "R8 done pulse after last word", 64'(init_done), 64'd1);
                chk(busy == 1'b0, "R8 idle at done", 64'(busy), 64'd0);
                pend_done = 0;
            end else if (init_done) begin
                chk(1'b0, "R8 stray init_done", 64'd1, 64'd0);
            end
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            if (!rst_n) begin
                mst = 0;
            end else begin
                if (mst == 0 && mem_req) begin
                    mst = 1;
                    gcnt = cur_gl;
                end else if (mst == 1) begin
                    chk(mem_req && mem_addr == exp_base + 24'(2*served), "R3 request held stable",
                        64'(mem_addr), 64'(exp_base + 24'(2*served)));
                end
                if (mst == 1) begin
                    if (gcnt == 0) begin
                        chk(mem_addr == exp_base + 24'(2*served) && served < NW, "R3 word address",
                            64'(mem_addr), 64'(exp_base + 24'(2*served)));
                        mem_gnt = 1'b1;
                        mst = 2;
                        rcnt = cur_rl;
                    end else gcnt--;
                end else if (mst == 2) begin
                    if (rcnt == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata = img(cur_v, served);
                        served++;
                        if (served == NW) pend_done = 1;
                        mst = 0;
                    end else rcnt--;
                end
            end
        end
    end

    task automatic start_vec(int v);
        cur_v = v; cur_gl = V_GL[v]; cur_rl = V_RL[v];
        exp_base = V_BASE[v] & ~24'd1;
        served = 0;
        base_addr = V_BASE[v];
        init_cmd = 1'b1;
        @(negedge clk);
        init_cmd = 1'b0;
        base_addr = 24'h5A5A5B;
        chk(busy == 1'b1 && mem_req == 1'b1, "R2 fetch starts", {busy, mem_req}, 2'b11);
        chk(tx_on == 1'b0 && rx_on == 1'b0, "R9 flags cleared at start", {tx_on, rx_on}, 2'b00);
    endtask

    task automatic run_vec(int v, bit mid_init);
        logic [15:0] w [NW];
        logic [23:0] erx, etx;
        logic [1:0]  eopm;
        bit seen = 0;
        for (int k = 0; k < NW; k++) w[k] = img(v, k);
        start_vec(v);
        for (int c = 0; c < 400 && !seen; c++) begin
            if (mid_init && c == 5) begin
                base_addr = 24'h123456;
                init_cmd = 1'b1;
            end else begin
                init_cmd = 1'b0;
            end
            @(negedge clk);
            if (init_done) seen = 1;
        end
        init_cmd = 1'b0;
        chk(seen, "R8 fetch completes", 64'(seen), 64'd1);
        chk(served == NW, mid_init ? "R11 word count after ignored INIT" : "R3 word count",
            64'(served), 64'(NW));
        chk(mode_word == w[0], "R12 mode word", 64'(mode_word), 64'(w[0]));
        chk(station_addr == {w[3], w[2], w[1]}, "R4 station address",
            64'(station_addr), 64'({w[3], w[2], w[1]}));
        chk(mcast_mask == {w[7], w[6], w[5], w[4]}, "R5 multicast mask",
            mcast_mask, {w[7], w[6], w[5], w[4]});
        erx = {w[9][7:0], w[8][15:3], 3'b000};
        etx = {w[11][7:0], w[10][15:3], 3'b000};
        chk(rx_ring_addr == erx, "R6 rx ring address", 64'(rx_ring_addr), 64'(erx));
        chk(tx_ring_addr == etx, "R6 tx ring address", 64'(tx_ring_addr), 64'(etx));
        chk(rx_ring_entries == 8'd1 << V_RXC[v], "R7 rx entries", 64'(rx_ring_entries), 64'(8'd1 << V_RXC[v]));
        chk(tx_ring_entries == 8'd1 << V_TXC[v], "R7 tx entries", 64'(tx_ring_entries), 64'(8'd1 << V_TXC[v]));
        chk(tx_on == !V_MODE[v][1] && rx_on == !V_MODE[v][0], "R9 on flags",
            {tx_on, rx_on}, {!V_MODE[v][1], !V_MODE[v][0]});
        eopm = !V_MODE[v][2] ? 2'd0 : (V_MODE[v][6] ? 2'd2 : 2'd1);
        chk(op_mode == eopm, "R10 operating mode", 64'(op_mode), 64'(eopm));
        @(negedge clk);
        chk(init_done == 1'b0 && mem_req == 1'b0 && busy == 1'b0, "R8 pulse ends and block idles",
            {init_done, mem_req, busy}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && init_done == 0 && mem_req == 0 && tx_on == 0 && rx_on == 0,
            "R1 reset state", {busy, init_done, mem_req, tx_on, rx_on}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) run_vec(v, v == 2);
        // reset in the middle of a fetch
        start_vec(0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 0 && mem_req == 0 && tx_on == 0 && rx_on == 0, "R1 reset aborts fetch",
            {busy, mem_req, tx_on, rx_on}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(3, 1'b0);
        run_vec(0, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule